// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block produces the result of a three-operand fused multiply-add (a * b + c) in the cases where at least one operand is a NaN. Operands are half-precision words. Each operand is classed as a quiet NaN, a signaling NaN or not a NaN. The block raises the invalid-operation flag where that is required. It then either returns one operand in quieted form or returns the default NaN. The arithmetic datapath decides that the NaN case applies and drives `case_valid`. A separate policy unit decides which operand wins and supplies a two-bit pick code.

The block is purely combinational. The infinity-times-zero hint from the multiplier can also raise invalid on its own; a build parameter enables this. The default-NaN mode input overrides the pick code. A guard makes sure that the output is always a quiet NaN, even when the pick code names an operand that is not a NaN.

Top module: `fma_nan_select`

## Requirements
- R1: An operand is a NaN when bits 14:10 are all ones and bits 9:0 are nonzero. It is quiet when bit 9 is set and signaling when bit 9 is clear. An infinity (bits 9:0 zero) is not a NaN.
- R2: With `case_valid` high, `invalid_flag` is 1 whenever any of `op_a`, `op_b` or `op_c` is a signaling NaN, whatever the other inputs are.
- R3: With `case_valid` high and the default build, `inf_times_zero` high sets `invalid_flag` even if all NaN operands are quiet. With the hint low and no signaling operand, `invalid_flag` is 0.
- R4: With `case_valid` and `dflt_mode` high, `nan_result` is 16'h7E00 whatever the pick code. `invalid_flag` still follows R2 and R3.
- R5: Pick codes 2'b00, 2'b01 and 2'b10 return `op_a`, `op_b` and `op_c` respectively, with bit 9 forced to 1 and every other bit (sign and payload included) unchanged.
- R6: Pick code 2'b11 returns the default NaN 16'h7E00.
- R7: If the operand named by the pick code is not a NaN (a number or an infinity), `nan_result` is 16'h7E00.
- R8: With `case_valid` low, `invalid_flag` is 0 and `nan_result` is 16'h0000, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| case_valid | input | 1 | The current operation is a NaN case; the outputs apply |
| op_a | input | 16 | First multiplicand, half precision |
| op_b | input | 16 | Second multiplicand, half precision |
| op_c | input | 16 | Addend, half precision |
| inf_times_zero | input | 1 | The product was infinity times zero |
| dflt_mode | input | 1 | Always return the default NaN |
| pick_code | input | 2 | Operand choice from the policy unit: 0 a, 1 b, 2 c, 3 default |
| nan_result | output | 16 | Quiet NaN result |
| invalid_flag | output | 1 | Invalid-operation exception |

## Verification
The assertions assume that all inputs change together and then hold for at least one evaluation. They do not assume that `case_valid` agrees with the operands: the result-is-quiet-NaN property must hold even when no operand is a NaN. The stimulus applies one complete input vector per clock cycle and keeps it stable until after the sample point. It mixes legal NaN cases with deliberately inconsistent pick codes, so that the R7 guard is driven as well.

// File: rtl/fnan_pkg.sv
package fnan_pkg;

    localparam int N_OPS = 3;

    typedef enum logic [1:0] {
        SEL_OP_A    = 2'd0,
        SEL_OP_B    = 2'd1,
        SEL_OP_C    = 2'd2,
        SEL_DEFAULT = 2'd3
    } nan_pick_e;

    typedef struct packed {
        logic is_nan;
        logic is_quiet;
        logic is_sig;
    } nan_kind_t;

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
    import fnan_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    localparam int MAG_W = EXP_W + FRAC_W
) (
    input  logic [MAG_W-1:0] mag,
    output nan_kind_t        kind
);
    logic exp_ones;
    logic frac_nz;
    logic quiet_bit;

    always_comb begin
        exp_ones      = &mag[MAG_W-1:FRAC_W];
        frac_nz       = |mag[FRAC_W-1:0];
        quiet_bit     = mag[FRAC_W-1];
        kind.is_nan   = exp_ones & frac_nz;
        kind.is_quiet = exp_ones & quiet_bit;
        kind.is_sig   = exp_ones & frac_nz & ~quiet_bit;
    end
endmodule

// File: rtl/fnan_quieten.sv
module fnan_quieten #(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] quiet
);
    localparam logic [WORD_W-1:0] QMASK = WORD_W'(1) << (FRAC_W - 1);

    always_comb quiet = raw | QMASK;
endmodule

// File: rtl/fnan_arbiter.sv
module fnan_arbiter
    import fnan_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [N_OPS-1:0][WORD_W-1:0] quiet_ops,
    input  nan_kind_t [N_OPS-1:0]        kinds,
    input  logic [1:0]                   pick_code,
    input  logic                         dflt_mode,
    output logic [WORD_W-1:0]            chosen,
    output logic                         use_default
);
    nan_pick_e pick;

    always_comb begin
        pick        = nan_pick_e'(pick_code);
        chosen      = '0;
        use_default = 1'b1;
        unique case (pick)
            SEL_OP_A: begin
                chosen      = quiet_ops[0];
                use_default = ~kinds[0].is_nan;
            end
            SEL_OP_B: begin
                chosen      = quiet_ops[1];
                use_default = ~kinds[1].is_nan;
            end
            SEL_OP_C: begin
                chosen      = quiet_ops[2];
                use_default = ~kinds[2].is_nan;
            end
            SEL_DEFAULT: begin
                chosen      = '0;
                use_default = 1'b1;
            end
        endcase
        if (dflt_mode) use_default = 1'b1;
    end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fnan_pkg::*;
#(
    parameter int EXP_W          = 5,
    parameter int FRAC_W         = 10,
    parameter bit INFZERO_RAISES = 1'b1,
    localparam int WORD_W        = 1 + EXP_W + FRAC_W
) (
    input  logic              case_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    input  logic              inf_times_zero,
    input  logic              dflt_mode,
    input  logic [1:0]        pick_code,
    output logic [WORD_W-1:0] nan_result,
    output logic              invalid_flag
);
    localparam int MAG_W = EXP_W + FRAC_W;
    localparam logic [WORD_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [N_OPS-1:0][WORD_W-1:0] raw_ops;
    logic [N_OPS-1:0][WORD_W-1:0] quiet_ops;
    nan_kind_t [N_OPS-1:0]        kinds;
    logic [N_OPS-1:0]             sig_vec;
    logic [WORD_W-1:0]            chosen;
    logic                         use_default;
    logic                         iz_raise;

    assign raw_ops[0] = op_a;
    assign raw_ops[1] = op_b;
    assign raw_ops[2] = op_c;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        fnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .mag  (raw_ops[g][MAG_W-1:0]),
            .kind (kinds[g])
        );
        fnan_quieten #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
            .raw   (raw_ops[g]),
            .quiet (quiet_ops[g])
        );
        assign sig_vec[g] = kinds[g].is_sig;
    end

    if (INFZERO_RAISES) begin : g_iz_on
        assign iz_raise = inf_times_zero;
    end else begin : g_iz_off
        logic iz_unused;
        assign iz_unused = inf_times_zero;
        assign iz_raise  = 1'b0 & iz_unused;
    end

    fnan_arbiter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_arb (
        .quiet_ops   (quiet_ops),
        .kinds       (kinds),
        .pick_code   (pick_code),
        .dflt_mode   (dflt_mode),
        .chosen      (chosen),
        .use_default (use_default)
    );

    always_comb begin
        if (!case_valid) begin
            nan_result   = '0;
            invalid_flag = 1'b0;
        end else begin
            nan_result   = use_default ? DEFAULT_NAN : chosen;
            invalid_flag = (|sig_vec) | iz_raise;
        end
    end
endmodule

// File: rtl/fnan_checker.sv
module fnan_checker #(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              case_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic [WORD_W-1:0] op_c,
    input logic              inf_times_zero,
    input logic              dflt_mode,
    input logic [1:0]        pick_code,
    input logic [WORD_W-1:0] nan_result,
    input logic              invalid_flag
);
    localparam logic [WORD_W-1:0] DNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    function automatic logic snan_word(input logic [WORD_W-1:0] w);
        return (&w[WORD_W-2:FRAC_W]) && !w[FRAC_W-1] && (|w[FRAC_W-2:0]);
    endfunction

    logic any_snan;
    logic iz_seen;
    always_comb begin
        any_snan = snan_word(op_a) | snan_word(op_b) | snan_word(op_c);
        iz_seen  = inf_times_zero;
    end

    always_comb begin
        AST_SNAN_RAISES: assert (!(case_valid && any_snan) || invalid_flag)
            else $error("sNaN operand did not raise invalid"); // R2
        AST_IDLE_SILENT: assert (case_valid || (!invalid_flag && nan_result == '0))
            else $error("outputs active while idle"); // R8
        AST_DFLT_OVERRIDE: assert (!(case_valid && dflt_mode) || nan_result == DNAN)
            else $error("default mode ignored"); // R4
        AST_RESULT_QNAN: assert (!case_valid || ((&nan_result[WORD_W-2:FRAC_W]) && nan_result[FRAC_W-1]))
            else $error("result is not a quiet NaN"); // R7
        AST_PICK3_DEFAULT: assert (!(case_valid && pick_code == 2'd3) || nan_result == DNAN)
            else $error("pick code 3 not default"); // R6
        AST_QUIET_NO_RAISE: assert (!(case_valid && !any_snan && !iz_seen) || !invalid_flag)
            else $error("spurious invalid"); // R3
    end
endmodule

bind fma_nan_select fnan_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .case_valid     (case_valid),
    .op_a           (op_a),
    .op_b           (op_b),
    .op_c           (op_c),
    .inf_times_zero (inf_times_zero),
    .dflt_mode      (dflt_mode),
    .pick_code      (pick_code),
    .nan_result     (nan_result),
    .invalid_flag   (invalid_flag)
);

// File: tb/sim_fma_nan_select.sv
module sim_fma_nan_select;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] res;
        logic        inv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        case_valid = 1'b0;
    logic [15:0] op_a = '0, op_b = '0, op_c = '0;
    logic        inf_times_zero = 1'b0;
    logic        dflt_mode = 1'b0;
    logic [1:0]  pick_code = '0;
    logic [15:0] nan_result;
    logic        invalid_flag;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    string tag_q[$];

    localparam logic [15:0] DNAN = 16'h7E00;
    localparam logic [15:0] ONE  = 16'h3C00;
    localparam logic [15:0] INF  = 16'h7C00;

    fma_nan_select u0 (
        .case_valid     (case_valid),
        .op_a           (op_a),
        .op_b           (op_b),
        .op_c           (op_c),
        .inf_times_zero (inf_times_zero),
        .dflt_mode      (dflt_mode),
        .pick_code      (pick_code),
        .nan_result     (nan_result),
        .invalid_flag   (invalid_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic iz, input logic dm,
                         input logic [1:0] pk, input logic [15:0] e_res,
                         input logic e_inv, input string tag);
        exp_t e;
        @(posedge clk);
        case_valid = v; op_a = a; op_b = b; op_c = c;
        inf_times_zero = iz; dflt_mode = dm; pick_code = pk;
        e.res = e_res; e.inv = e_inv;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (!rst && exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (nan_result !== e.res || invalid_flag !== e.inv) begin
                    n_errors++;
                    $display("FAIL %s: result=%h exp=%h invalid=%b exp=%b",
                             t, nan_result, e.res, invalid_flag, e.inv);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_errors++;
            $display("FAIL watchdog: result=%h exp=done invalid=%b exp=done", nan_result, invalid_flag);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R8: idle state after reset, outputs silent
        drive(0, 16'h7C05, ONE, ONE, 0, 0, 2'd0, 16'h0000, 0, "R8 idle");
        // R2 R5: signaling a forwarded quieted
        drive(1, 16'h7C05, ONE, ONE, 0, 0, 2'd0, 16'h7E05, 1, "R2 R5 sNaN a");
        // R5: negative sNaN b keeps sign and payload
        drive(1, ONE, 16'hFC81, ONE, 0, 0, 2'd1, 16'hFE81, 1, "R5 neg b");
        // R5 R3: quiet c, no raise
        drive(1, ONE, ONE, 16'h7E01, 0, 0, 2'd2, 16'h7E01, 0, "R5 R3 quiet c");
        // R6: pick code 3
        drive(1, ONE, ONE, 16'h7E01, 0, 0, 2'd3, DNAN, 0, "R6 pick default");
        // R4: default mode with sNaN still raises
        drive(1, 16'h7C05, ONE, ONE, 0, 1, 2'd0, DNAN, 1, "R4 dflt sNaN");
        // R4: default mode with quiet c
        drive(1, ONE, ONE, 16'hFF00, 0, 1, 2'd2, DNAN, 0, "R4 dflt quiet");
        // R3: inf times zero hint raises with quiet c
        drive(1, 16'h0000, INF, 16'h7E01, 1, 0, 2'd2, 16'h7E01, 1, "R3 inf*zero");
        // R7: pick names a number
        drive(1, ONE, ONE, 16'h7E01, 0, 0, 2'd0, DNAN, 0, "R7 pick number");
        // R1 R7: infinity is not a NaN
        drive(1, INF, ONE, 16'h7E01, 0, 0, 2'd0, DNAN, 0, "R1 R7 pick inf");
        // R1: smallest signaling payload
        drive(1, ONE, ONE, 16'h7C01, 0, 0, 2'd2, 16'h7E01, 1, "R1 min sNaN");
        // R1 R5: full payload, negative
        drive(1, 16'hFDFF, ONE, ONE, 0, 0, 2'd0, 16'hFFFF, 1, "R1 R5 full payload");
        // R8: idle with sNaN and hint
        drive(0, 16'h7C05, 16'h7C05, 16'h7C05, 1, 1, 2'd1, 16'h0000, 0, "R8 idle busy inputs");
        // R5: all quiet, pick b
        drive(1, 16'h7E10, 16'h7F00, 16'h7E01, 0, 0, 2'd1, 16'h7F00, 0, "R5 all quiet b");
        // R2: sNaN only in c, a picked
        drive(1, 16'h7E10, ONE, 16'h7C40, 0, 0, 2'd0, 16'h7E10, 1, "R2 sNaN c pick a");
        // R3: hint with default mode
        drive(1, INF, 16'h0000, 16'h7E01, 1, 1, 2'd2, DNAN, 1, "R3 R4 hint dflt");
        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule